// File: doc/BRIEF.md
# Disk Adapter Host Register Interface

This block is the host side of a hard-disk adapter. It decodes eight byte-wide ports at consecutive offsets on a simple 8-bit read/write bus. The host uses them to read a subsystem status word, to load a 16-bit pointer to a command parameter block, to start a command, and to collect the outcome of that command as a result type and a result byte. A separate command engine executes the command. It receives a one-cycle start pulse together with the pointer, and it reports back a completion strobe that carries the result type, the result code and an interrupt request.

The block holds an interrupt flip-flop, which drives the interrupt output and appears in the status word. Reading the result-type port acknowledges the interrupt. Each drive has a ready flag. The flag is set by a rising edge on that drive's attach input, and a soft reset reloads it from the current attach levels. The soft reset is triggered by a write to the highest port.

Top module: `dkc_host_regs`

## Requirements
- R1: After rst_ni is released, status (offset 0) reads 0x88, result type (offset 1) reads 0x00, result byte (offset 3) reads 0x00, and start_o and irq_o are low.
- R2: The status byte holds drive 0 ready in bit 0, drive 1 ready in bit 1, the interrupt flip-flop in bit 2, controller present (always 1) in bit 3, and a sticky flag in bit 7. Bits 4 to 6 read 0.
- R3: A write to offset 1 loads bits 7:0 of blk_ptr_o and produces no start pulse. blk_ptr_o changes only on pointer writes.
- R4: A write to offset 2 loads bits 15:8 of blk_ptr_o. In the cycle after that write, start_o is high for exactly one cycle.
- R5: A read of offset 1 returns the result type in bits 1:0, with the other bits 0. At the clock edge that ends the read, the interrupt flip-flop (status bit 2, irq_o) and status bit 7 are cleared. A completion with an interrupt request in the same cycle wins.
- R6: When done_i is high, the block latches res_type_i and res_code_i. If done_irq_i is also high, it sets the interrupt flip-flop, so that irq_o and status bit 2 go high in the next cycle.
- R7: A read of offset 3 returns the result code when the result type is 0 (error). When the result type is 2 (ready status), it returns drive 0 ready in bit 6 and drive 1 ready in bit 7, with all other bits 0.
- R8: Any write to offset 7 is a soft reset. Status becomes 0x88 plus the ready bits of the drives whose attach input is high. The result type and result code become 0, and the interrupt flip-flop is cleared. A soft reset takes priority over a completion in the same cycle.
- R9: A rising edge on drv_attach_i[n] sets drive n's ready flag in the status byte and in the ready-status result, and clears the result code.
- R10: Reads of offsets 2, 4, 5 and 6 return 0x00, and bus_rdata_o is 0x00 when no read is active. A write to offset 3 changes no readable state.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Port offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the cycle of the read |
| drv_attach_i | input | 2 | Per-drive attach level |
| start_o | output | 1 | One-cycle command start pulse |
| blk_ptr_o | output | 16 | Parameter-block pointer |
| done_i | input | 1 | Command completion strobe |
| done_irq_i | input | 1 | Completion requests an interrupt |
| res_type_i | input | 2 | Result type from the engine |
| res_code_i | input | 8 | Result code from the engine |
| irq_o | output | 1 | Interrupt flip-flop |

## Verification
The bench checks that a write to offset 1 never starts a command, and that a write to offset 2 starts exactly one. A design that starts on the low-byte write, or that holds start high, would launch spurious or repeated commands. The bench checks that reading the result type both acknowledges the interrupt and clears status bit 7. It also checks that a completion without an interrupt request leaves irq_o low. The result-byte multiplexer is tested in both result types and with each drive attached in turn. A swapped bit 6 and bit 7 would report the wrong drive as ready. A soft reset issued while an interrupt is pending and both drives are attached must clear the interrupt and the results, yet keep both drives ready.

// File: rtl/dkc_host_pkg.sv
package dkc_host_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int PTR_W   = 2 * DATA_W;
  localparam int NUM_OFS = 1 << ADDR_W;
  localparam int RTYPE_W = 2;

  localparam logic [ADDR_W-1:0] OFS_STAT  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_RTYPE = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_PTRHI = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_RBYTE = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_SRST  = 3'd7;

  typedef enum logic [RTYPE_W-1:0] {
    RT_ERR = 2'd0,
    RT_RSV = 2'd1,
    RT_RDY = 2'd2,
    RT_RS3 = 2'd3
  } rtype_e;
endpackage

// File: rtl/dkc_addr_dec.sv
module dkc_addr_dec
  import dkc_host_pkg::*;
(
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_OFS-1:0] rd_o,
  output logic [NUM_OFS-1:0] wr_o
);
  for (genvar g = 0; g < NUM_OFS; g++) begin : g_ofs
    assign rd_o[g] = sel_i && !wr_i && (addr_i == ADDR_W'(g));
    assign wr_o[g] = sel_i &&  wr_i && (addr_i == ADDR_W'(g));
  end
endmodule

// File: rtl/dkc_drive_ready.sv
module dkc_drive_ready #(
  parameter int NUM_DRV = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_DRV-1:0] attach_i,
  input  logic               soft_rst_i,
  output logic               any_rise_o,
  output logic [NUM_DRV-1:0] ready_o
);
  logic [NUM_DRV-1:0] prev_q, rise;

  for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
    assign rise[g] = attach_i[g] && !prev_q[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[g]  <= 1'b0;
        ready_o[g] <= 1'b0;
      end else begin
        prev_q[g] <= attach_i[g];
        if (soft_rst_i)   ready_o[g] <= attach_i[g];
        else if (rise[g]) ready_o[g] <= 1'b1;
      end
    end
  end

  assign any_rise_o = |rise;
endmodule

// File: rtl/dkc_ptr_regs.sv
module dkc_ptr_regs
  import dkc_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o   <= '0;
      start_o <= 1'b0;
    end else begin
      start_o <= wr_hi_i;
      if (wr_lo_i) ptr_o[DATA_W-1:0]     <= wdata_i;
      if (wr_hi_i) ptr_o[PTR_W-1:DATA_W] <= wdata_i;
    end
  end
endmodule

// File: rtl/dkc_host_regs.sv
module dkc_host_regs
  import dkc_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic [1:0]        drv_attach_i,
  output logic              start_o,
  output logic [15:0]       blk_ptr_o,
  input  logic              done_i,
  input  logic              done_irq_i,
  input  logic [1:0]        res_type_i,
  input  logic [7:0]        res_code_i,
  output logic              irq_o
);
  localparam int NUM_DRV = 2;

  logic [NUM_OFS-1:0] rd_s, wr_s;
  logic [NUM_DRV-1:0] ready;
  logic               any_rise;
  logic               irq_q, flag7_q, present_q;
  rtype_e             rtype_q;
  logic [DATA_W-1:0]  code_q, stat_q, rbyte;

  dkc_addr_dec i_dec (
    .sel_i (bus_sel_i), .wr_i (bus_wr_i), .addr_i (bus_addr_i),
    .rd_o  (rd_s),      .wr_o (wr_s)
  );

  dkc_drive_ready #(.NUM_DRV(NUM_DRV)) i_rdy (
    .clk_i (clk_i), .rst_ni (rst_ni), .attach_i (drv_attach_i),
    .soft_rst_i (wr_s[OFS_SRST]), .any_rise_o (any_rise), .ready_o (ready)
  );

  dkc_ptr_regs i_ptr (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .wr_lo_i (wr_s[OFS_RTYPE]), .wr_hi_i (wr_s[OFS_PTRHI]),
    .wdata_i (bus_wdata_i), .ptr_o (blk_ptr_o), .start_o (start_o)
  );

  // soft reset > completion > acknowledge / attach
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q     <= 1'b0;
      flag7_q   <= 1'b1;
      present_q <= 1'b1;
      rtype_q   <= RT_ERR;
      code_q    <= '0;
    end else if (wr_s[OFS_SRST]) begin
      irq_q     <= 1'b0;
      flag7_q   <= 1'b1;
      present_q <= 1'b1;
      rtype_q   <= RT_ERR;
      code_q    <= '0;
    end else begin
      if (rd_s[OFS_RTYPE]) begin
        irq_q   <= 1'b0;
        flag7_q <= 1'b0;
      end
      if (any_rise) code_q <= '0;
      if (done_i) begin
        rtype_q <= rtype_e'(res_type_i);
        code_q  <= res_code_i;
        if (done_irq_i) irq_q <= 1'b1;
      end
    end
  end

  assign stat_q = {flag7_q, 3'b000, present_q, irq_q, ready};
  assign rbyte  = (rtype_q == RT_RDY) ? {ready[1], ready[0], 6'b0} : code_q;
  assign irq_o  = irq_q;

  always_comb begin
    bus_rdata_o = '0;
    if (rd_s[OFS_STAT])  bus_rdata_o = stat_q;
    if (rd_s[OFS_RTYPE]) bus_rdata_o = {6'b0, rtype_q};
    if (rd_s[OFS_RBYTE]) bus_rdata_o = rbyte;
  end
endmodule

// File: rtl/dkc_host_chk.sv
module dkc_host_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_sel_i,
  input logic        bus_wr_i,
  input logic [2:0]  bus_addr_i,
  input logic        start_o,
  input logic [15:0] blk_ptr_o,
  input logic        irq_o,
  input logic        done_i,
  input logic        done_irq_i,
  input logic [7:0]  stat_q
);
  logic wr_lo, wr_hi, wr_rst, rd_ack, irq_ev;
  assign wr_lo  = bus_sel_i && bus_wr_i  && bus_addr_i == 3'd1;
  assign wr_hi  = bus_sel_i && bus_wr_i  && bus_addr_i == 3'd2;
  assign wr_rst = bus_sel_i && bus_wr_i  && bus_addr_i == 3'd7;
  assign rd_ack = bus_sel_i && !bus_wr_i && bus_addr_i == 3'd1;
  assign irq_ev = done_i && done_irq_i;

  // R4
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  // R4
  start_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi |=> start_o);
  // R3
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_lo || wr_hi) |=> $stable(blk_ptr_o));
  // R5
  irq_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ack && !irq_ev && !wr_rst) |=> (!irq_o && !stat_q[7]));
  // R6
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ev && !wr_rst) |=> (irq_o && stat_q[2]));
  // R8
  soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rst |=> (stat_q[3] && stat_q[7] && !irq_o));
endmodule

bind dkc_host_regs dkc_host_chk i_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .bus_sel_i (bus_sel_i),
  .bus_wr_i (bus_wr_i), .bus_addr_i (bus_addr_i), .start_o (start_o),
  .blk_ptr_o (blk_ptr_o), .irq_o (irq_o), .done_i (done_i),
  .done_irq_i (done_irq_i), .stat_q (stat_q)
);

// File: tb/test_dkc_host_regs.sv
module test_dkc_host_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 0, wr = 0, done = 0, dirq = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata, code = '0;
  logic [1:0] attach = '0, rtype = '0;
  logic start, irq;
  logic [15:0] ptr;
  int errors = 0, checks = 0;
  logic start_seen;

  always #10 clk = ~clk;

  dkc_host_regs i_dkc_host_regs (
    .clk_i (clk), .rst_ni (rst_n), .bus_sel_i (sel), .bus_wr_i (wr),
    .bus_addr_i (addr), .bus_wdata_i (wdata), .bus_rdata_o (rdata),
    .drv_attach_i (attach), .start_o (start), .blk_ptr_o (ptr),
    .done_i (done), .done_irq_i (dirq), .res_type_i (rtype),
    .res_code_i (code), .irq_o (irq)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0; start_seen = start;
  endtask

  task automatic brd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = a;
    #2 d = rdata;
    @(negedge clk); sel = 0;
  endtask

  task automatic rchk(string req, logic [2:0] a, logic [7:0] exp);
    logic [7:0] d;
    brd(a, d);
    chk(req, {8'h0, d}, {8'h0, exp});
  endtask

  task automatic complete(logic [1:0] t, logic [7:0] c, logic i);
    @(negedge clk); done = 1; rtype = t; code = c; dirq = i;
    @(negedge clk); done = 0; dirq = 0;
  endtask

  // {op(1=read,2=write), addr, wdata, expected read}
  localparam int NV = 11;
  localparam logic [20:0] VEC [NV] = '{
    {2'd1, 3'd0, 8'h00, 8'h88},  // R1 R2
    {2'd1, 3'd1, 8'h00, 8'h00},  // R1
    {2'd1, 3'd3, 8'h00, 8'h00},  // R1
    {2'd1, 3'd2, 8'h00, 8'h00},  // R10
    {2'd1, 3'd4, 8'h00, 8'h00},  // R10
    {2'd1, 3'd5, 8'h00, 8'h00},  // R10
    {2'd1, 3'd6, 8'h00, 8'h00},  // R10
    {2'd2, 3'd3, 8'h5A, 8'h00},  // R10
    {2'd1, 3'd3, 8'h00, 8'h00},  // R10
    {2'd2, 3'd7, 8'hFF, 8'h00},  // R8
    {2'd1, 3'd0, 8'h00, 8'h88}   // R8
  };

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 start", {15'h0, start}, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20:19] == 2'd2) bwr(VEC[i][18:16], VEC[i][15:8]);
      else begin
        brd(VEC[i][18:16], d);
        chk($sformatf("R10 vec%0d", i), {8'h0, d}, {8'h0, VEC[i][7:0]});
      end
    end

    // pointer and start
    bwr(3'd1, 8'h34);
    chk("R3 no start on low", {15'h0, start_seen}, 16'h0);
    bwr(3'd2, 8'h12);
    chk("R4 start", {15'h0, start_seen}, 16'h1);
    chk("R4 ptr", ptr, 16'h1234);
    @(negedge clk);
    chk("R4 single pulse", {15'h0, start}, 16'h0);
    repeat (4) @(negedge clk);
    chk("R3 ptr stable", ptr, 16'h1234);
    bwr(3'd1, 8'h56);
    chk("R3 low only", ptr, 16'h1256);

    // completion with interrupt
    complete(2'd0, 8'h04, 1'b1);
    chk("R6 irq", {15'h0, irq}, 16'h1);
    rchk("R6 R2 status", 3'd0, 8'h8C);
    rchk("R7 code", 3'd3, 8'h04);
    rchk("R5 type", 3'd1, 8'h00);
    chk("R5 ack", {15'h0, irq}, 16'h0);
    rchk("R5 status", 3'd0, 8'h08);

    // completion without interrupt
    complete(2'd0, 8'h20, 1'b0);
    chk("R6 no irq", {15'h0, irq}, 16'h0);
    rchk("R6 code", 3'd3, 8'h20);

    // attach drive 1
    @(negedge clk); attach = 2'b10;
    @(negedge clk);
    rchk("R9 status d1", 3'd0, 8'h0A);
    rchk("R9 code cleared", 3'd3, 8'h00);
    complete(2'd2, 8'h11, 1'b0);
    rchk("R5 type rdy", 3'd1, 8'h02);
    rchk("R7 rdy d1", 3'd3, 8'h80);
    @(negedge clk); attach = 2'b11;
    @(negedge clk);
    rchk("R9 status both", 3'd0, 8'h0B);
    rchk("R7 rdy both", 3'd3, 8'hC0);

    // soft reset with pending interrupt
    complete(2'd0, 8'h80, 1'b1);
    rchk("R2 status irq", 3'd0, 8'h0F);
    bwr(3'd7, 8'h00);
    chk("R8 irq cleared", {15'h0, irq}, 16'h0);
    rchk("R8 status", 3'd0, 8'h8B);
    rchk("R8 type", 3'd1, 8'h00);
    rchk("R8 code", 3'd3, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule